// File: doc/BRIEF.md
# Tone Bin Parameter Estimator

This block turns a frame's luma histogram into three 2-bit tone-control parameters for a local contrast enhancer. It runs in the gap between the first pass over a frame and its enhancement pass. After a start pulse it steps through every luma code from the frame's minimum to its maximum, one code per clock. For each code it reads the pixel count from the unstretched histogram and the stretched value from the freshly built stretch table. The stretched value decides whether that count goes into the dark, middle or bright bin.

When the sweep ends, the upper bits of each bin total are compared with fixed fractions of the frame's pixel count. Each bin's share of the frame is then mapped inversely onto a 2-bit code. The dark bin gives the dark-gain parameter, the middle bin gives the lobe-width parameter, and the bright bin gives the bright-gain parameter. There are two parameter sets, one for odd frames and one for even frames. A sweep writes the set named at start, and a separate select input picks the set that drives the outputs. The enhancer can therefore use one frame's parameters while the next frame's parameters are being estimated.

Top module: `tone_param_est`

## Requirements
- R1: After an accepted start, `code_o` takes the values `ymin_i` to `ymax_i` (latched at start), one per cycle in rising order. `bank_o` holds the latched bank for the whole sweep. `hist_cnt_i` and `stretch_i` are sampled for the code shown on `code_o`. `ymin_i` must not exceed `ymax_i`.
- R2: A stretched value of 0..85 selects the dark bin. A value of 86..169 selects the middle bin. A value of 170..255 selects the bright bin.
- R3: The three 19-bit bin accumulators are cleared by each accepted start. Histogram entries for codes outside [ymin, ymax] contribute nothing.
- R4: Only bits [18:11] of each bin total are used. They are compared with bits [18:11] of three thresholds: N>>2, N>>1, and (N>>1)+(N>>2). N is `npix_i`, latched at start.
- R5: Let v be the kept bin value. The code is 00 when v is above the three-quarter threshold. Otherwise it is 01 when v is above the half threshold. Otherwise it is 10 when v is at or above the quarter threshold. Otherwise it is 11.
- R6: The dark bin sets `mdark_o`, the middle bin sets `lobe_o` and the bright bin sets `mbright_o`.
- R7: `done_o` is a one-cycle pulse on the edge N+1 clocks after the start edge, where N = ymax-ymin+1. The new parameters are readable in the same cycle that `done_o` is high.
- R8: Two parameter sets exist. A sweep writes only the set selected by `bank_i` at start. `sel_i` picks the set shown on the outputs, and the outputs change only when `sel_i` changes or a sweep completes.
- R9: A start pulse while `busy_o` is high is ignored. It changes neither the sweep in progress, its timing, nor its result.
- R10: After reset `busy_o` and `done_o` are 0, and both parameter sets read 00 for all three parameters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a sweep (accepted when idle) |
| bank_i | input | 1 | Parameter set written by this sweep |
| ymin_i | input | 8 | First luma code of the sweep |
| ymax_i | input | 8 | Last luma code of the sweep |
| npix_i | input | 19 | Pixel count of the frame |
| code_o | output | 8 | Luma code currently read |
| bank_o | output | 1 | Histogram/table bank currently read |
| hist_cnt_i | input | 19 | Histogram count for `code_o` |
| stretch_i | input | 8 | Stretched value for `code_o` |
| busy_o | output | 1 | Sweep or quantisation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| sel_i | input | 1 | Parameter set shown on outputs |
| mdark_o | output | 2 | Dark-gain parameter |
| lobe_o | output | 2 | Lobe-width parameter |
| mbright_o | output | 2 | Bright-gain parameter |

## Verification
A start accepted on one edge shows the first code on `code_o` right after that edge. The last code is summed N edges later, and `done_o` with fresh parameters follows exactly one edge after that. The bench counts edges from the start edge and requires `done_o` at count N+1 and not earlier. It reads the parameters only while `done_o` is high and checks `done_o` low again one edge later. Set selection is combinational, so parameter reads after a change of `sel_i` are sampled one time step after the drive, away from any clock edge.

// File: rtl/tone_est_pkg.sv
package tone_est_pkg;
  localparam int NUM_BINS = 3;
  localparam int BIN_DARK = 0;
  localparam int BIN_MID  = 1;
  localparam int BIN_BRT  = 2;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SWEEP = 2'd1,
    ST_QUANT = 2'd2
  } est_state_e;
endpackage

// File: rtl/tone_bin_sorter.sv
module tone_bin_sorter import tone_est_pkg::*; #(
  parameter int Y_W = 8
) (
  input  logic [Y_W-1:0]      stretch_i,
  output logic [NUM_BINS-1:0] hit_o
);
  localparam int FULL  = (1 << Y_W) - 1;
  localparam int LO_TH = FULL / 3;
  localparam int HI_TH = (2 * FULL) / 3;

  always_comb begin
    hit_o           = '0;
    hit_o[BIN_DARK] = (32'(stretch_i) <= LO_TH);
    hit_o[BIN_BRT]  = (32'(stretch_i) >= HI_TH);
    hit_o[BIN_MID]  = !hit_o[BIN_DARK] && !hit_o[BIN_BRT];
  end
endmodule

// File: rtl/tone_bin_acc.sv
module tone_bin_acc import tone_est_pkg::*; #(
  parameter int ACC_W = 19
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           clr_i,
  input  logic                           en_i,
  input  logic [NUM_BINS-1:0]            hit_i,
  input  logic [ACC_W-1:0]               cnt_i,
  output logic [NUM_BINS-1:0][ACC_W-1:0] sum_o
);
  for (genvar b = 0; b < NUM_BINS; b++) begin : g_bin
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                 sum_o[b] <= '0;
      else if (clr_i)              sum_o[b] <= '0;
      else if (en_i && hit_i[b])   sum_o[b] <= sum_o[b] + cnt_i;
    end
  end
endmodule

// File: rtl/tone_param_quant.sv
module tone_param_quant import tone_est_pkg::*; #(
  parameter int ACC_W  = 19,
  parameter int KEEP_W = 8
) (
  input  logic [ACC_W-1:0]               npix_i,
  input  logic [NUM_BINS-1:0][ACC_W-1:0] sum_i,
  output logic [NUM_BINS-1:0][1:0]       par_o
);
  localparam int DROP = ACC_W - KEEP_W;

  logic [KEEP_W-1:0] th_q1, th_h, th_q3;

  always_comb begin
    th_q1 = KEEP_W'((npix_i >> 2) >> DROP);
    th_h  = KEEP_W'((npix_i >> 1) >> DROP);
    th_q3 = KEEP_W'(((npix_i >> 1) + (npix_i >> 2)) >> DROP);
  end

  for (genvar b = 0; b < NUM_BINS; b++) begin : g_q
    logic [KEEP_W-1:0] kept;
    always_comb begin
      kept = KEEP_W'(sum_i[b] >> DROP);
      if (kept > th_q3)       par_o[b] = 2'b00;
      else if (kept > th_h)   par_o[b] = 2'b01;
      else if (kept >= th_q1) par_o[b] = 2'b10;
      else                    par_o[b] = 2'b11;
    end
  end
endmodule

// File: rtl/tone_param_est.sv
module tone_param_est import tone_est_pkg::*; #(
  parameter int Y_W      = 8,
  parameter int ACC_W    = 19,
  parameter int KEEP_W   = 8,
  parameter int NUM_SETS = 2,
  localparam int SEL_W   = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [SEL_W-1:0] bank_i,
  input  logic [Y_W-1:0]   ymin_i,
  input  logic [Y_W-1:0]   ymax_i,
  input  logic [ACC_W-1:0] npix_i,
  output logic [Y_W-1:0]   code_o,
  output logic [SEL_W-1:0] bank_o,
  input  logic [ACC_W-1:0] hist_cnt_i,
  input  logic [Y_W-1:0]   stretch_i,
  output logic             busy_o,
  output logic             done_o,
  input  logic [SEL_W-1:0] sel_i,
  output logic [1:0]       mdark_o,
  output logic [1:0]       lobe_o,
  output logic [1:0]       mbright_o
);
  est_state_e       state_q;
  logic [Y_W-1:0]   code_q, ymax_q;
  logic [SEL_W-1:0] bank_q;
  logic [ACC_W-1:0] npix_q;
  logic             done_q;
  logic             take;

  logic [NUM_BINS-1:0]            hit;
  logic [NUM_BINS-1:0][ACC_W-1:0] sums;
  logic [NUM_BINS-1:0][1:0]       par_new;
  logic [NUM_BINS-1:0][1:0]       par_q [NUM_SETS];

  assign take = (state_q == ST_IDLE) && start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      code_q  <= '0;
      ymax_q  <= '0;
      bank_q  <= '0;
      npix_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_SWEEP;
          code_q  <= ymin_i;
          ymax_q  <= ymax_i;
          bank_q  <= bank_i;
          npix_q  <= npix_i;
        end
        ST_SWEEP: begin
          if (code_q == ymax_q) state_q <= ST_QUANT;
          else                  code_q  <= code_q + 1'b1;
        end
        ST_QUANT: begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  tone_bin_sorter #(.Y_W(Y_W)) u_sort (
    .stretch_i (stretch_i),
    .hit_o     (hit)
  );

  tone_bin_acc #(.ACC_W(ACC_W)) u_acc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (take),
    .en_i   (state_q == ST_SWEEP),
    .hit_i  (hit),
    .cnt_i  (hist_cnt_i),
    .sum_o  (sums)
  );

  tone_param_quant #(.ACC_W(ACC_W), .KEEP_W(KEEP_W)) u_quant (
    .npix_i (npix_q),
    .sum_i  (sums),
    .par_o  (par_new)
  );

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        par_q[s] <= '0;
      else if (state_q == ST_QUANT && bank_q == SEL_W'(s))
        par_q[s] <= par_new;
    end
  end

  assign code_o    = code_q;
  assign bank_o    = bank_q;
  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = done_q;
  assign mdark_o   = par_q[sel_i][BIN_DARK];
  assign lobe_o    = par_q[sel_i][BIN_MID];
  assign mbright_o = par_q[sel_i][BIN_BRT];
endmodule

// File: rtl/tone_param_est_chk.sv
module tone_param_est_chk import tone_est_pkg::*; #(
  parameter int Y_W   = 8,
  parameter int ACC_W = 19,
  parameter int SEL_W = 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             busy_o,
  input logic             done_o,
  input logic [SEL_W-1:0] sel_i,
  input logic [SEL_W-1:0] bank_o,
  input logic [Y_W-1:0]   code_o,
  input logic [1:0]       mdark_o,
  input logic [1:0]       lobe_o,
  input logic [1:0]       mbright_o,
  input est_state_e       state_q,
  input logic [Y_W-1:0]   ymax_q,
  input logic [ACC_W-1:0] npix_q
);
  p_code_step_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SWEEP && $past(state_q) == ST_SWEEP) |-> code_o == $past(code_o) + 1'b1);

  p_code_range_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SWEEP) |-> code_o <= ymax_q);

  p_bank_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(bank_o));

  p_done_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_at_end_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  p_params_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!done_o && sel_i == $past(sel_i)) |->
      {mdark_o, lobe_o, mbright_o} == $past({mdark_o, lobe_o, mbright_o}));

  p_start_ignored_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> ($stable(ymax_q) && $stable(npix_q)));
endmodule

bind tone_param_est tone_param_est_chk #(.Y_W(Y_W), .ACC_W(ACC_W), .SEL_W(SEL_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .sel_i     (sel_i),
  .bank_o    (bank_o),
  .code_o    (code_o),
  .mdark_o   (mdark_o),
  .lobe_o    (lobe_o),
  .mbright_o (mbright_o),
  .state_q   (state_q),
  .ymax_q    (ymax_q),
  .npix_q    (npix_q)
);

// File: tb/tone_param_est_bench.sv
`timescale 1ns/1ps
module tone_param_est_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic        bank_i = 1'b0;
  logic [7:0]  ymin_i = '0, ymax_i = '0;
  logic [18:0] npix_i = '0;
  logic [7:0]  code_o;
  logic        bank_o;
  logic [18:0] hist_cnt_i;
  logic [7:0]  stretch_i;
  logic        busy_o, done_o;
  logic        sel_i = 1'b0;
  logic [1:0]  mdark_o, lobe_o, mbright_o;

  logic [18:0] hist_mem [256];
  logic [7:0]  str_mem  [256];

  int checks = 0;
  int errors = 0;

  always #2.5 clk_i = ~clk_i;

  assign hist_cnt_i = hist_mem[code_o];
  assign stretch_i  = str_mem[code_o];

  tone_param_est u_tone_param_est (
    .clk_i, .rst_ni, .start_i, .bank_i, .ymin_i, .ymax_i, .npix_i,
    .code_o, .bank_o, .hist_cnt_i, .stretch_i, .busy_o, .done_o,
    .sel_i, .mdark_o, .lobe_o, .mbright_o
  );

  typedef struct packed {
    logic [18:0] d, m, b;
    logic [1:0]  md, lo, mb;
  } vec_t;

  // counts at codes 10/128/200 with identity stretch, N = 2^18
  localparam vec_t VECS [5] = '{
    '{19'd200000, 19'd40000,  19'd22144,  2'b00, 2'b11, 2'b11},
    '{19'd140000, 19'd80000,  19'd42144,  2'b01, 2'b10, 2'b11},
    '{19'd0,      19'd65536,  19'd196608, 2'b11, 2'b10, 2'b01},
    '{19'd65535,  19'd131073, 19'd65536,  2'b11, 2'b10, 2'b10},
    '{19'd0,      19'd0,      19'd262144, 2'b11, 2'b11, 2'b00}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_par(input string req, input logic [1:0] md, lo, mb);
    chk({req, " mdark"},   int'(mdark_o),   int'(md));
    chk({req, " lobe"},    int'(lobe_o),    int'(lo));
    chk({req, " mbright"}, int'(mbright_o), int'(mb));
  endtask

  task automatic clear_mem();
    for (int x = 0; x < 256; x++) begin
      hist_mem[x] = '0;
      str_mem[x]  = 8'(x);
    end
  endtask

  // runs a sweep, checks R7 latency and pulse, leaves sel_i = bank
  task automatic run(input string req, input logic bank, input logic [7:0] lo_c, hi_c,
                     input int inject_at, input logic [1:0] md, lo, mb);
    int n = int'(hi_c) - int'(lo_c) + 1;
    int cnt = 0;
    bit seen = 0;
    @(negedge clk_i);
    start_i = 1'b1; bank_i = bank; ymin_i = lo_c; ymax_i = hi_c; npix_i = 19'd262144;
    sel_i = bank;
    @(posedge clk_i);
    @(negedge clk_i);
    start_i = 1'b0;
    for (int c = 0; c < 2000; c++) begin
      @(posedge clk_i); #1;
      cnt++;
      if (done_o) begin seen = 1; break; end
      if (cnt == inject_at) begin
        start_i = 1'b1; ymin_i = 8'd200; ymax_i = 8'd201; bank_i = ~bank; npix_i = 19'd1;
      end else start_i = 1'b0;
    end
    start_i = 1'b0;
    chk({req, " R7 done seen"}, int'(seen), 1);
    chk({req, " R7 latency"}, cnt, n + 1);
    chk_par({req, " R5 R6"}, md, lo, mb);
    @(posedge clk_i); #1;
    chk({req, " R7 single pulse"}, int'(done_o), 0);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    clear_mem();
    repeat (3) @(posedge clk_i);
    #1;
    // R10 reset state
    chk("R10 busy", int'(busy_o), 0);
    chk("R10 done", int'(done_o), 0);
    chk_par("R10 set0", 2'b00, 2'b00, 2'b00);
    sel_i = 1'b1; #1;
    chk_par("R10 set1", 2'b00, 2'b00, 2'b00);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R4 R5 R6 R7 vector table, banks alternate
    for (int i = 0; i < 5; i++) begin
      clear_mem();
      hist_mem[10]  = VECS[i].d;
      hist_mem[128] = VECS[i].m;
      hist_mem[200] = VECS[i].b;
      run($sformatf("vec%0d R4", i), 1'(i % 2), 8'd0, 8'd255, 0,
          VECS[i].md, VECS[i].lo, VECS[i].mb);
    end

    // R8 sets independent
    sel_i = 1'b0; #1;
    chk_par("R8 set0 keeps vec4", 2'b11, 2'b11, 2'b00);
    sel_i = 1'b1; #1;
    chk_par("R8 set1 keeps vec3", 2'b11, 2'b10, 2'b10);

    // R3 out-of-range codes ignored, accumulators cleared
    clear_mem();
    hist_mem[10] = 19'd262144;  str_mem[10]  = 8'd0;
    hist_mem[120] = 19'd262144; str_mem[120] = 8'd200;
    hist_mem[200] = 19'd262144;
    run("R3 range", 1'b1, 8'd100, 8'd150, 0, 2'b11, 2'b11, 2'b00);

    // R2 bin edges 85/86/169/170
    clear_mem();
    str_mem[50] = 8'd85; str_mem[51] = 8'd86; str_mem[52] = 8'd169; str_mem[53] = 8'd170;
    hist_mem[50] = 19'd200000; hist_mem[51] = 19'd70000; hist_mem[53] = 19'd140000;
    run("R2 edge a", 1'b0, 8'd50, 8'd53, 0, 2'b00, 2'b10, 2'b01);
    hist_mem[50] = 19'd70000; hist_mem[51] = 19'd0; hist_mem[52] = 19'd200000; hist_mem[53] = 19'd0;
    run("R2 edge b", 1'b1, 8'd50, 8'd53, 0, 2'b10, 2'b00, 2'b11);
    sel_i = 1'b0; #1;
    chk_par("R8 set0 untouched", 2'b00, 2'b10, 2'b01);

    // R1 single-code sweep
    clear_mem();
    hist_mem[77] = 19'd262144; str_mem[77] = 8'd128;
    run("R1 single code", 1'b0, 8'd77, 8'd77, 0, 2'b11, 2'b00, 2'b11);

    // R9 start during sweep ignored
    clear_mem();
    hist_mem[10] = VECS[0].d; hist_mem[128] = VECS[0].m; hist_mem[200] = VECS[0].b;
    run("R9 restart ignored", 1'b1, 8'd0, 8'd255, 20, 2'b00, 2'b11, 2'b11);
    sel_i = 1'b0; #1;
    chk_par("R9 R8 other set unchanged", 2'b11, 2'b00, 2'b11);
    chk("R9 idle after", int'(busy_o), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule